// File: doc/BRIEF.md
# One-Wire Search Path Accelerator

This block speeds up the enumeration of 64-bit identity codes on a one-wire bus. It handles four code bits for each byte the host writes. For each code bit it asks a bit-slot engine for two read slots: the first returns the bit, the second returns its complement. From those two values and the host's preferred branch it picks the direction to follow. It then asks for one write slot that sends that direction back on the bus. After four such triplets it places a packed result byte in a receive buffer. A full 64-bit code takes sixteen such bytes. Byte i covers code bits 4i to 4i+3. The host decides the next search path from the returned discrepancy flags.

When search mode is off, a written byte is sent as a plain transfer. This is eight write slots, least significant bit first. Each slot's sampled bus level is collected into the received byte. The block talks to the slot engine through a request/acknowledge pair. A request is held until it is acknowledged. The acknowledge cycle carries the sampled bit.

The sequencer has these states:
- `S_IDLE`: waits for a host write.
- `S_RD_TRUE`: requests the true-bit read slot.
- `S_RD_CMPL`: requests the complement read slot.
- `S_WR_DIR`: writes back the chosen direction.
- `S_PLAIN`: runs one plain write slot.
- `S_FINISH`: loads the receive buffer.

The transitions are:
- `S_IDLE` to `S_RD_TRUE` on a write in search mode.
- `S_IDLE` to `S_PLAIN` on a write in plain mode.
- `S_RD_TRUE` to `S_RD_CMPL` on acknowledge.
- `S_RD_CMPL` to `S_WR_DIR` on acknowledge.
- `S_WR_DIR` back to `S_RD_TRUE` on acknowledge while pairs remain, otherwise to `S_FINISH`.
- `S_PLAIN` to itself on acknowledge while bits remain, otherwise to `S_FINISH`.
- `S_FINISH` to `S_IDLE` always.

Top module: `owsa_search_accel`

## Requirements
- R1: The level of `mode_srch` at the accepted write selects the handling. A value of 1 selects a search byte. A value of 0 selects a plain byte transfer.
- R2: In a search byte, the preferred direction for nibble bit k (k = 0..3) is taken from `wr_data` bit 2k+1. The even input bits are not used.
- R3: In a search result, bit 2k+1 holds the chosen direction for nibble bit k. Bit 2k holds its discrepancy flag.
- R4: A true/complement read pair of (0,1) chooses 0 with no discrepancy. A pair of (1,0) chooses 1 with no discrepancy.
- R5: A pair of (1,1) means no device answered. The chosen bit and the discrepancy flag are then both 1.
- R6: A pair of (0,0) sets the discrepancy flag. The chosen bit then equals the host's preferred bit.
- R7: For each nibble bit, the slot order is read, read, write. The write slot sends the chosen bit. `slot_op` is 0 for a read slot and 1 for a write slot. `slot_op` and `slot_wbit` stay stable while a request waits for acknowledge.
- R8: `rx_full` rises only after every slot of the byte has been acknowledged. A `rd_pop` pulse clears it.
- R9: A `wr_valid` pulse while `busy` is high is ignored. It changes neither the slots nor the result.
- R10: After reset, `rx_full`, `busy`, `slot_req` and `rx_data` are all 0.
- R11: A plain transfer issues eight write slots, least significant bit first. Each slot sends the corresponding `wr_data` bit. Its acknowledged `slot_rbit` becomes the same bit of `rx_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_srch | input | 1 | 1 = search byte, 0 = plain byte (sampled on the accepted write) |
| wr_valid | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| rd_pop | input | 1 | Host has read the receive buffer; clears `rx_full` |
| rx_data | output | 8 | Receive buffer |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| busy | output | 1 | A byte is in progress |
| slot_req | output | 1 | Slot request to the bit-slot engine |
| slot_op | output | 1 | 0 = read slot, 1 = write slot |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_ack | input | 1 | Slot done, one cycle |
| slot_rbit | input | 1 | Sampled bus bit, valid with `slot_ack` |

## Verification
The bench builds the block with its default 8-bit byte, which gives four search pairs per byte. That small width lets it sweep all 256 combinations of true/complement read values across the four pairs. Each combination is run under four preferred-direction patterns, so every decision rule meets every preference at every bit position. The slot engine model acknowledges after a fixed wait. It logs each slot's kind and written bit, which lets the bench compare the write-back order against arithmetic expectations. Plain transfers are swept over a spread of byte values and two bus pull-down masks.

// File: rtl/owsa_pkg.sv
package owsa_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_TRUE,
        S_RD_CMPL,
        S_WR_DIR,
        S_PLAIN,
        S_FINISH
    } owsa_state_e;

    localparam logic OP_READ  = 1'b0;
    localparam logic OP_WRITE = 1'b1;
endpackage

// File: rtl/owsa_decide.sv
module owsa_decide (
    input  logic t_bit,
    input  logic c_bit,
    input  logic pref,
    output logic dir,
    output logic disc
);
    always_comb begin
        unique case ({t_bit, c_bit})
            2'b01:   begin dir = 1'b0; disc = 1'b0; end
            2'b10:   begin dir = 1'b1; disc = 1'b0; end
            2'b11:   begin dir = 1'b1; disc = 1'b1; end
            default: begin dir = pref; disc = 1'b1; end
        endcase
    end
endmodule

// File: rtl/owsa_pack.sv
module owsa_pack #(
    parameter int BYTE_W = 8,
    localparam int PAIRS = BYTE_W / 2
) (
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [PAIRS-1:0]  dir_v,
    input  logic [PAIRS-1:0]  disc_v,
    output logic [PAIRS-1:0]  pref_v,
    output logic [BYTE_W-1:0] packed_out
);
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        assign pref_v[k]           = byte_in[2*k+1];
        assign packed_out[2*k+1]   = dir_v[k];
        assign packed_out[2*k]     = disc_v[k];
    end
endmodule

// File: rtl/owsa_fsm.sv
module owsa_fsm
    import owsa_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int PAIRS = BYTE_W / 2,
    localparam int IDX_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_srch,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_pop,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    output logic              busy,
    output logic              slot_req,
    output logic              slot_op,
    output logic              slot_wbit,
    input  logic              slot_ack,
    input  logic              slot_rbit,
    output logic [BYTE_W-1:0] in_byte,
    input  logic [PAIRS-1:0]  pref_v,
    output logic [PAIRS-1:0]  dir_v,
    output logic [PAIRS-1:0]  disc_v,
    input  logic [BYTE_W-1:0] packed_in,
    output logic              dec_t,
    output logic              dec_c,
    output logic              dec_pref,
    input  logic              dec_dir,
    input  logic              dec_disc
);
    localparam logic [IDX_W-1:0] LAST_PAIR = IDX_W'(PAIRS - 1);
    localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(BYTE_W - 1);

    owsa_state_e       state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic              mode_q;
    logic [BYTE_W-1:0] in_q;
    logic              t_q;
    logic              c_q;
    logic [PAIRS-1:0]  dir_q;
    logic [PAIRS-1:0]  disc_q;
    logic [BYTE_W-1:0] pl_q;
    logic [BYTE_W-1:0] rx_q;
    logic              full_q;
    logic [1:0]        pair_sel;

    assign pair_sel = idx_q[1:0];
    assign in_byte  = in_q;
    assign dir_v    = dir_q;
    assign disc_v   = disc_q;
    assign dec_t    = t_q;
    assign dec_c    = slot_rbit;
    assign dec_pref = pref_v[idx_q[$clog2(PAIRS)-1:0]];
    assign rx_data  = rx_q;
    assign rx_full  = full_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (wr_valid) state_d = mode_srch ? S_RD_TRUE : S_PLAIN;
            S_RD_TRUE: if (slot_ack) state_d = S_RD_CMPL;
            S_RD_CMPL: if (slot_ack) state_d = S_WR_DIR;
            S_WR_DIR:  if (slot_ack) state_d = (idx_q == LAST_PAIR) ? S_FINISH : S_RD_TRUE;
            S_PLAIN:   if (slot_ack && idx_q == LAST_BIT) state_d = S_FINISH;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        slot_req  = 1'b0;
        slot_op   = OP_READ;
        slot_wbit = 1'b1;
        busy      = (state_q != S_IDLE);
        unique case (state_q)
            S_RD_TRUE, S_RD_CMPL: slot_req = 1'b1;
            S_WR_DIR: begin
                slot_req  = 1'b1;
                slot_op   = OP_WRITE;
                slot_wbit = dir_q[idx_q[$clog2(PAIRS)-1:0]];
            end
            S_PLAIN: begin
                slot_req  = 1'b1;
                slot_op   = OP_WRITE;
                slot_wbit = in_q[idx_q];
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            mode_q <= 1'b0;
            in_q   <= '0;
            t_q    <= 1'b0;
            c_q    <= 1'b0;
            dir_q  <= '0;
            disc_q <= '0;
            pl_q   <= '0;
            rx_q   <= '0;
            full_q <= 1'b0;
        end else begin
            if (rd_pop) full_q <= 1'b0;
            unique case (state_q)
                S_IDLE: if (wr_valid) begin
                    idx_q  <= '0;
                    mode_q <= mode_srch;
                    in_q   <= wr_data;
                    dir_q  <= '0;
                    disc_q <= '0;
                    pl_q   <= '0;
                end
                S_RD_TRUE: if (slot_ack) t_q <= slot_rbit;
                S_RD_CMPL: if (slot_ack) begin
                    c_q                                 <= slot_rbit;
                    dir_q[idx_q[$clog2(PAIRS)-1:0]]     <= dec_dir;
                    disc_q[idx_q[$clog2(PAIRS)-1:0]]    <= dec_disc;
                end
                S_WR_DIR: if (slot_ack && idx_q != LAST_PAIR) idx_q <= idx_q + 1'b1;
                S_PLAIN: if (slot_ack) begin
                    pl_q[idx_q] <= slot_rbit;
                    if (idx_q != LAST_BIT) idx_q <= idx_q + 1'b1;
                end
                S_FINISH: begin
                    rx_q   <= mode_q ? packed_in : pl_q;
                    full_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R7: a waiting request keeps its kind and data
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && !slot_ack) |=> (slot_req && $stable(slot_op) && $stable(slot_wbit)));

    // R8: buffer fills only from the finishing step
    a_r8_full_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_q) |-> ($past(state_q) == S_FINISH));

    // R9: the captured byte does not move while a byte is in progress
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(in_q));

    // R11: plain transfers issue only write slots
    a_r11_plain_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && !mode_q) |-> (slot_op == OP_WRITE));

    // R4: a (1,0) read pair writes back a 1
    a_r4_true_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WR_DIR && t_q && !c_q) |-> slot_wbit);

    // R4: a (0,1) read pair writes back a 0
    a_r4_cmpl_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WR_DIR && !t_q && c_q) |-> !slot_wbit);
endmodule

// File: rtl/owsa_search_accel.sv
module owsa_search_accel #(
    parameter int BYTE_W = 8,
    localparam int PAIRS = BYTE_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_srch,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_pop,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    output logic              busy,
    output logic              slot_req,
    output logic              slot_op,
    output logic              slot_wbit,
    input  logic              slot_ack,
    input  logic              slot_rbit
);
    logic [BYTE_W-1:0] in_byte;
    logic [BYTE_W-1:0] packed_byte;
    logic [PAIRS-1:0]  pref_v;
    logic [PAIRS-1:0]  dir_v;
    logic [PAIRS-1:0]  disc_v;
    logic              dec_t;
    logic              dec_c;
    logic              dec_pref;
    logic              dec_dir;
    logic              dec_disc;

    owsa_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_srch (mode_srch),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .rd_pop    (rd_pop),
        .rx_data   (rx_data),
        .rx_full   (rx_full),
        .busy      (busy),
        .slot_req  (slot_req),
        .slot_op   (slot_op),
        .slot_wbit (slot_wbit),
        .slot_ack  (slot_ack),
        .slot_rbit (slot_rbit),
        .in_byte   (in_byte),
        .pref_v    (pref_v),
        .dir_v     (dir_v),
        .disc_v    (disc_v),
        .packed_in (packed_byte),
        .dec_t     (dec_t),
        .dec_c     (dec_c),
        .dec_pref  (dec_pref),
        .dec_dir   (dec_dir),
        .dec_disc  (dec_disc)
    );

    owsa_decide u_decide (
        .t_bit (dec_t),
        .c_bit (dec_c),
        .pref  (dec_pref),
        .dir   (dec_dir),
        .disc  (dec_disc)
    );

    owsa_pack #(.BYTE_W(BYTE_W)) u_pack (
        .byte_in    (in_byte),
        .dir_v      (dir_v),
        .disc_v     (disc_v),
        .pref_v     (pref_v),
        .packed_out (packed_byte)
    );
endmodule

// File: tb/owsa_search_accel_test.sv
module owsa_search_accel_test;
    localparam int LAT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_srch = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_pop = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full;
    logic       busy;
    logic       slot_req;
    logic       slot_op;
    logic       slot_wbit;
    logic       slot_ack = 1'b0;
    logic       slot_rbit = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // engine model state
    logic [3:0] tpat = '0;
    logic [3:0] cpat = '0;
    logic [7:0] pmask = 8'hFF;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int op_cnt = 0;
    int wait_cnt = 0;
    logic [15:0] op_log = '0;
    logic [7:0]  wlog = '0;

    always #4 clk = ~clk;

    owsa_search_accel uut (
        .clk(clk), .rst_n(rst_n), .mode_srch(mode_srch), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_pop(rd_pop), .rx_data(rx_data), .rx_full(rx_full),
        .busy(busy), .slot_req(slot_req), .slot_op(slot_op), .slot_wbit(slot_wbit),
        .slot_ack(slot_ack), .slot_rbit(slot_rbit)
    );

    // bit-slot engine model: acknowledges after a fixed wait
    always @(posedge clk) begin
        slot_ack <= 1'b0;
        if (wr_valid && !busy) begin
            rd_cnt <= 0; wr_cnt <= 0; op_cnt <= 0; wait_cnt <= 0;
        end else if (slot_req && !slot_ack) begin
            if (wait_cnt == LAT) begin
                wait_cnt <= 0;
                slot_ack <= 1'b1;
                if (op_cnt < 16) op_log[op_cnt] <= slot_op;
                op_cnt <= op_cnt + 1;
                if (slot_op == 1'b0) begin
                    slot_rbit <= rd_cnt[0] ? cpat[(rd_cnt>>1)&3] : tpat[(rd_cnt>>1)&3];
                    rd_cnt <= rd_cnt + 1;
                end else begin
                    if (wr_cnt < 8) wlog[wr_cnt] <= slot_wbit;
                    slot_rbit <= slot_wbit & pmask[wr_cnt&7];
                    wr_cnt <= wr_cnt + 1;
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic m, input logic [7:0] b);
        @(negedge clk);
        mode_srch = m;
        wr_data   = b;
        wr_valid  = 1'b1;
        @(negedge clk);
        wr_valid  = 1'b0;
    endtask

    // wait for the buffer, checking it fills only after all slots (R8)
    task automatic wait_full(input int n_ops);
        int guard = 0;
        while (!rx_full && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        chk("R8 rx_full timing", rx_full ? op_cnt : -1, n_ops);
    endtask

    task automatic pop();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_search(input logic [3:0] pref, input logic [3:0] t, input logic [3:0] c);
        logic [7:0]  b;
        logic [7:0]  exp_rx;
        logic [3:0]  exp_w;
        logic [15:0] exp_ops;
        tpat = t; cpat = c; pmask = 8'hFF;
        // preference on odd bits (R2), junk on even bits
        b = {pref[3], 1'b1, pref[2], 1'b0, pref[1], 1'b1, pref[0], 1'b0};
        exp_rx = '0; exp_w = '0; exp_ops = '0;
        for (int k = 0; k < 4; k++) begin
            logic d, f;
            case ({t[k], c[k]})
                2'b01: begin d = 1'b0; f = 1'b0; end   // R4
                2'b10: begin d = 1'b1; f = 1'b0; end   // R4
                2'b11: begin d = 1'b1; f = 1'b1; end   // R5
                default: begin d = pref[k]; f = 1'b1; end // R6
            endcase
            exp_rx[2*k+1] = d;   // R3
            exp_rx[2*k]   = f;
            exp_w[k]      = d;
            exp_ops[3*k+2] = 1'b1;
        end
        send(1'b1, b);
        wait_full(12);
        chk("R3 R4 R5 R6 search result", rx_data, exp_rx);
        chk("R7 write-back bits", wlog[3:0], exp_w);
        chk("R7 slot order", op_log[11:0], exp_ops[11:0]);
        pop();
    endtask

    task automatic run_plain(input logic [7:0] b, input logic [7:0] m);
        pmask = m;
        send(1'b0, b);
        wait_full(8);
        chk("R11 plain received", rx_data, b & m);
        chk("R11 plain sent bits", wlog, b);
        chk("R1 plain uses write slots only", op_log[7:0], 8'hFF);
        pop();
    endtask

    initial begin
        logic [3:0] prefs [4];
        prefs[0] = 4'h0; prefs[1] = 4'h5; prefs[2] = 4'hA; prefs[3] = 4'hF;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 rx_full", rx_full, 0);
        chk("R10 busy", busy, 0);
        chk("R10 slot_req", slot_req, 0);
        chk("R10 rx_data", rx_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // exhaustive sweep of read pairs across four preferences
        for (int p = 0; p < 4; p++) begin
            for (int v = 0; v < 256; v++) begin
                logic [3:0] t, c;
                for (int k = 0; k < 4; k++) begin
                    t[k] = v[2*k+1];
                    c[k] = v[2*k];
                end
                run_search(prefs[p], t, c);
            end
        end

        // R8: pop clears the buffer
        run_search(4'h3, 4'h0, 4'hF);
        chk("R8 cleared by pop", rx_full, 0);

        // R9: a write while busy is ignored
        tpat = 4'h0; cpat = 4'h0; pmask = 8'hFF;
        send(1'b1, 8'hAA);
        repeat (5) @(negedge clk);
        chk("R9 busy during byte", busy, 1);
        send(1'b0, 8'h00);
        wait_full(12);
        chk("R9 result unaffected", rx_data, 8'hFF);
        chk("R9 slots unaffected", op_cnt, 12);
        pop();

        // R1 / R11: plain transfers
        for (int i = 0; i < 256; i += 17) begin
            run_plain(8'(i), 8'hFF);
            run_plain(8'(i), 8'h5A);
        end
        // R1: the same byte in search mode is handled as a search
        run_search(4'hF, 4'hA, 4'h5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule